// File: doc/BRIEF.md
# Fetch-Decode-Execute Teaching Processor Core

This block is a small multi-cycle processor for a teaching machine. It holds sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. It reaches a 256-cell byte-wide memory through a synchronous port. Every instruction is 16 bits wide. The top 4 bits are the op-code and the remaining 12 bits are three operand nibbles: hi is bits 11:8, mid is bits 7:4 and lo is bits 3:0. The low byte, bits 7:0, serves as an address or an immediate value.

The core fetches the two bytes of an instruction, high byte first, and advances the program counter by two. It then decodes the op-code and carries out a load, store, move, add, bitwise logic, rotate, jump or halt. Conditional jumps compare the register named by the hi nibble with R0 and use no flags. A halt instruction parks the core. The `halted` output stays high until the next reset.

The memory answers a read one cycle after it sees an address. For this reason the core holds each fetch or load address for two cycles and captures the data in the second. A fetch takes four cycles and execution takes one more, so an instruction costs five cycles. A memory load costs six.

Top module: `fdeCore`

## Requirements
- R1: A synchronous reset clears the program counter and all sixteen registers to zero. During reset and on release, `memAddr` is 0x00, `halted` is low and `memWrEn` is low.
- R2: The instruction register takes the byte at the program counter as its upper half and the byte at PC+1 as its lower half. The PC then advances by 2. Each instruction without a memory load takes 5 clock cycles, so three no-ops followed by a halt raise `halted` 20 cycles after reset is released, with `memAddr` resting at 0x08.
- R3: The load op-codes each write one register. Op-code 0x2 writes the low byte into register hi (immediate). Op-code 0x1 writes the memory cell at the low byte into register hi (direct). Op-code 0xD writes the cell addressed by register lo into register mid (indirect).
- R4: The store op-codes each write one memory cell. Op-code 0x3 writes register hi to the cell at the low byte. Op-code 0xE writes register mid to the cell addressed by register lo. Each store asserts `memWrEn` for exactly one cycle.
- R5: Op-code 0x4 copies register mid into register lo. The hi nibble is ignored.
- R6: Op-code 0x5 writes register mid + register lo, modulo 256, into register hi.
- R7: Op-codes 0x7, 0x8 and 0x9 write the OR, AND and XOR of registers mid and lo into register hi.
- R8: Op-code 0xA rotates register hi right by the lo nibble modulo 8. The mid nibble is ignored.
- R9: Op-code 0xB loads the low byte into the PC when register hi equals R0. Op-code 0xF loads it when register hi is at most R0, compared unsigned. With hi = 0, op-code 0xB always jumps.
- R10: Op-codes 0x0 and 0x6 change no register and no memory cell.
- R11: Op-code 0xC raises `halted`, which stays high until reset. After the halt no further fetch or memory write occurs, and an instruction placed after the halt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 8 | Memory cell address |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Byte to write |
| memRdData | input | 8 | Read byte, valid one cycle after its address |
| halted | output | 1 | Core has executed a halt |

## Verification
The bench builds the core with its default widths: 8-bit data and addresses, and sixteen registers. With these widths every op-code and every operand nibble can be reached.

A 16-by-16 grid of operand values runs through the add, logic and no-op program. The same grid runs through both compare-and-jump kinds, which covers the equal, less and greater cases together with the 0x00 and 0xFF extremes.

Rotation is swept over all sixteen count values for eight patterns, which covers the wrap at a count of 8. Register indices are swept through the load, move and store forms, and the results are read back from memory cells written by the program itself.

// File: rtl/fdePkg.sv
package fdePkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int INSTR_W   = 2 * DATA_W;
  localparam int REG_COUNT = 16;
  localparam int SEL_W     = $clog2(REG_COUNT);
  localparam int OPC_W     = INSTR_W - 3 * SEL_W;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'h0, OP_LDD = 4'h1, OP_LDI  = 4'h2, OP_STD = 4'h3,
    OP_MOV  = 4'h4, OP_ADD = 4'h5, OP_FADD = 4'h6, OP_OR  = 4'h7,
    OP_AND  = 4'h8, OP_XOR = 4'h9, OP_ROR  = 4'hA, OP_JEQ = 4'hB,
    OP_HALT = 4'hC, OP_LDR = 4'hD, OP_STR  = 4'hE, OP_JLE = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {A_PC, A_PC1, A_IMM, A_REG} addrSel_e;
  typedef enum logic [1:0] {W_IMM, W_MEM, W_ALU, W_MOV} wbSel_e;
  typedef enum logic [1:0] {F_HI, F_MID, F_LO} fldSel_e;

  typedef struct packed {
    logic     irHiLd;
    logic     irLoLd;
    logic     pcAdv;
    logic     pcLoad;
    logic     regWr;
    logic     memWr;
    addrSel_e addrSel;
    wbSel_e   wbSel;
    fldSel_e  dstSel;
    fldSel_e  srcSel;
  } ctl_t;
endpackage

// File: rtl/fdeDatapath.sv
module fdeDatapath
  import fdePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output opcode_e           opcode,
  output logic              regEqR0,
  output logic              regLeR0
);
  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] ir;
  logic [DATA_W-1:0]  regs [REG_COUNT];

  logic [SEL_W-1:0]    fHi, fMid, fLo, dstIdx, srcIdx;
  logic [DATA_W-1:0]   imm, aluRes, wbData;
  logic [2*DATA_W-1:0] rotDbl;

  assign fHi    = ir[3*SEL_W-1:2*SEL_W];
  assign fMid   = ir[2*SEL_W-1:SEL_W];
  assign fLo    = ir[SEL_W-1:0];
  assign imm    = ir[DATA_W-1:0];
  assign opcode = opcode_e'(ir[INSTR_W-1:INSTR_W-OPC_W]);

  function automatic logic [SEL_W-1:0] pickField(fldSel_e s, logic [SEL_W-1:0] h,
                                                 logic [SEL_W-1:0] m, logic [SEL_W-1:0] l);
    case (s)
      F_HI:    return h;
      F_MID:   return m;
      default: return l;
    endcase
  endfunction

  assign dstIdx = pickField(ctl.dstSel, fHi, fMid, fLo);
  assign srcIdx = pickField(ctl.srcSel, fHi, fMid, fLo);

  assign rotDbl = {regs[fHi], regs[fHi]} >> (fLo % DATA_W);

  always_comb begin
    case (opcode)
      OP_ADD:  aluRes = regs[fMid] + regs[fLo];
      OP_OR:   aluRes = regs[fMid] | regs[fLo];
      OP_AND:  aluRes = regs[fMid] & regs[fLo];
      OP_XOR:  aluRes = regs[fMid] ^ regs[fLo];
      OP_ROR:  aluRes = rotDbl[DATA_W-1:0];
      default: aluRes = regs[fHi];
    endcase
  end

  always_comb begin
    case (ctl.wbSel)
      W_IMM:   wbData = imm;
      W_MEM:   wbData = memRdData;
      W_ALU:   wbData = aluRes;
      default: wbData = regs[fMid];
    endcase
  end

  always_comb begin
    case (ctl.addrSel)
      A_PC:    memAddr = pc;
      A_PC1:   memAddr = pc + ADDR_W'(1);
      A_IMM:   memAddr = imm;
      default: memAddr = regs[fLo];
    endcase
  end

  assign memWrData = regs[srcIdx];
  assign regEqR0   = (regs[fHi] == regs[0]);
  assign regLeR0   = (regs[fHi] <= regs[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else begin
      if (ctl.irHiLd) ir[INSTR_W-1:DATA_W] <= memRdData;
      if (ctl.irLoLd) ir[DATA_W-1:0] <= memRdData;
      if (ctl.pcAdv) pc <= pc + ADDR_W'(2);
      else if (ctl.pcLoad) pc <= imm;
      if (ctl.regWr) regs[dstIdx] <= wbData;
    end
  end
endmodule

// File: rtl/fdeControl.sv
module fdeControl
  import fdePkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e opcode,
  input  logic    regEqR0,
  input  logic    regLeR0,
  output ctl_t    ctl,
  output logic    halted
);
  typedef enum logic [2:0] {S_FHA, S_FHC, S_FLA, S_FLC, S_EXE, S_LDC, S_HLT} state_e;
  state_e state, nextState;

  always_comb begin
    ctl         = '0;
    ctl.addrSel = A_PC;
    ctl.wbSel   = W_ALU;
    ctl.dstSel  = F_HI;
    ctl.srcSel  = F_HI;
    nextState   = state;
    case (state)
      S_FHA: nextState = S_FHC;
      S_FHC: begin ctl.irHiLd = 1'b1; nextState = S_FLA; end
      S_FLA: begin ctl.addrSel = A_PC1; nextState = S_FLC; end
      S_FLC: begin
        ctl.addrSel = A_PC1;
        ctl.irLoLd  = 1'b1;
        ctl.pcAdv   = 1'b1;
        nextState   = S_EXE;
      end
      S_EXE: begin
        nextState = S_FHA;
        case (opcode)
          OP_LDD:  begin ctl.addrSel = A_IMM; nextState = S_LDC; end
          OP_LDR:  begin ctl.addrSel = A_REG; nextState = S_LDC; end
          OP_LDI:  begin ctl.regWr = 1'b1; ctl.wbSel = W_IMM; end
          OP_STD:  begin ctl.memWr = 1'b1; ctl.addrSel = A_IMM; end
          OP_STR:  begin ctl.memWr = 1'b1; ctl.addrSel = A_REG; ctl.srcSel = F_MID; end
          OP_MOV:  begin ctl.regWr = 1'b1; ctl.wbSel = W_MOV; ctl.dstSel = F_LO; end
          OP_ADD, OP_OR, OP_AND, OP_XOR, OP_ROR: ctl.regWr = 1'b1;
          OP_JEQ:  ctl.pcLoad = regEqR0;
          OP_JLE:  ctl.pcLoad = regLeR0;
          OP_HALT: nextState = S_HLT;
          default: ;
        endcase
      end
      S_LDC: begin
        ctl.addrSel = (opcode == OP_LDR) ? A_REG : A_IMM;
        ctl.dstSel  = (opcode == OP_LDR) ? F_MID : F_HI;
        ctl.wbSel   = W_MEM;
        ctl.regWr   = 1'b1;
        nextState   = S_FHA;
      end
      default: nextState = S_HLT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FHA;
    else     state <= nextState;
  end

  assign halted = (state == S_HLT);
endmodule

// File: rtl/fdeCore.sv
module fdeCore
  import fdePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              halted
);
  ctl_t    ctl;
  opcode_e opcode;
  logic    regEqR0, regLeR0;

  fdeControl uCtl (
    .clk(clk), .rst(rst), .opcode(opcode), .regEqR0(regEqR0),
    .regLeR0(regLeR0), .ctl(ctl), .halted(halted)
  );

  fdeDatapath uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .opcode(opcode),
    .regEqR0(regEqR0), .regLeR0(regLeR0)
  );

  assign memWrEn = ctl.memWr;
endmodule

// File: rtl/fdeChecker.sv
module fdeChecker
  import fdePkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWrEn,
  input logic              halted
);
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r11_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !memWrEn);

  a_r11_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(memAddr));

  a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
    memWrEn |=> !memWrEn);

  a_r11_halt_no_write_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> !memWrEn);
endmodule

bind fdeCore fdeChecker uChk (
  .clk(clk), .rst(rst), .memAddr(memAddr), .memWrEn(memWrEn), .halted(halted)
);

// File: tb/fdeCore_test.sv
`timescale 1ns/1ps
module fdeCore_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] memAddr, memWrData, memRdData;
  logic       memWrEn, halted;
  logic [7:0] mem [256];
  int         total = 0;
  int         fails = 0;
  int         pcB;
  int         lastCycles;

  always #2 clk = ~clk;

  fdeCore uut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData), .halted(halted)
  );

  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    memRdData <= mem[memAddr];
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    pcB = 0;
  endtask

  task automatic emit(logic [15:0] w);
    mem[pcB]     = w[15:8];
    mem[pcB + 1] = w[7:0];
    pcB += 2;
  endtask

  task automatic runProg();
    int n;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    lastCycles = n;
    if (!halted) chk("R11 halt not reached", 16'(n), 16'd0);
  endtask

  function automatic logic [7:0] rotr(logic [7:0] v, int c);
    int k = c % 8;
    return 8'((({v, v}) >> k) & 16'h00FF);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R11 watchdog expired act=%0d exp=%0d", 190000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1: reset state
    clearMem();
    emit(16'hC000);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 memAddr in reset", 16'(memAddr), 16'h00);
    chk("R1 halted in reset", 16'(halted), 16'h0);
    chk("R1 memWrEn in reset", 16'(memWrEn), 16'h0);

    // R2: three no-ops and halt, timing and resting address
    clearMem();
    emit(16'h0000); emit(16'h0123); emit(16'h0FFF); emit(16'hC000);
    runProg();
    chk("R2 cycles to halt", 16'(lastCycles), 16'd20);
    chk("R2 memAddr at halt", 16'(memAddr), 16'h08);
    repeat (5) @(negedge clk);
    chk("R11 halted sticky", 16'(halted), 16'h1);
    chk("R11 address frozen", 16'(memAddr), 16'h08);

    // R2: byte order of instruction
    clearMem();
    emit(16'h2A5C); emit(16'h3AF0); emit(16'hC000);
    runProg();
    chk("R2 high byte first", 16'(mem[8'hF0]), 16'h5C);

    // R6 R7 R10 R11: ALU grid
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] a, b;
        a = 8'(i * 17);
        b = 8'((j * 29 + 8'h80) & 8'hFF);
        clearMem();
        emit({8'h21, a}); emit({8'h22, b}); emit(16'h2777);
        emit(16'h5312); emit(16'h7412); emit(16'h8512); emit(16'h9612);
        emit(16'h6712); emit(16'h0712);
        emit(16'h33F0); emit(16'h34F1); emit(16'h35F2); emit(16'h36F3);
        emit(16'h37F4); emit(16'hC000); emit(16'h31F5);
        runProg();
        chk("R6 add", 16'(mem[8'hF0]), 16'(8'(a + b)));
        chk("R7 or", 16'(mem[8'hF1]), 16'(a | b));
        chk("R7 and", 16'(mem[8'hF2]), 16'(a & b));
        chk("R7 xor", 16'(mem[8'hF3]), 16'(a ^ b));
        chk("R10 nops keep reg", 16'(mem[8'hF4]), 16'h77);
        chk("R11 after halt ignored", 16'(mem[8'hF5]), 16'h00);
      end
    end

    // R1: registers are zero after reset
    clearMem();
    emit(16'h31F0); emit(16'h37F1); emit(16'h3FF2); emit(16'hC000);
    runProg();
    chk("R1 R1 zero", 16'(mem[8'hF0]), 16'h00);
    chk("R1 R7 zero", 16'(mem[8'hF1]), 16'h00);
    chk("R1 RF zero", 16'(mem[8'hF2]), 16'h00);

    // R8: rotate sweep
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic [7:0] v;
        v = 8'((p * 53 + 1) & 8'hFF) ^ 8'(1 << p);
        clearMem();
        emit({8'h21, v});
        emit(16'hA150 | 16'(c));
        emit(16'h31F0); emit(16'hC000);
        runProg();
        chk("R8 rotate", 16'(mem[8'hF0]), 16'(rotr(v, c)));
      end
    end

    // R3 R4 R5: loads, moves, stores across register indices
    for (int d = 1; d <= 13; d++) begin
      logic [7:0] v, w;
      logic [15:0] dn, en, an;
      int startCycles;
      v  = 8'(d * 11 + 3);
      w  = ~v;
      dn = 16'(d);
      en = 16'(d + 1);
      an = 16'(d + 2);
      clearMem();
      mem[8'hC0] = v;
      mem[8'hC1] = w;
      emit(16'h1000 | (dn << 8) | 16'hC0);
      emit(16'h4000 | (dn << 4) | en);
      emit(16'h3000 | (en << 8) | 16'hD0);
      emit(16'h2000 | (an << 8) | 16'hC1);
      emit(16'hD000 | (dn << 4) | an);
      emit(16'h2000 | (an << 8) | 16'hD1);
      emit(16'hE000 | (dn << 4) | an);
      emit(16'hC000);
      startCycles = 0;
      runProg();
      chk("R3 R5 load direct then move", 16'(mem[8'hD0]), 16'(v));
      chk("R3 R4 load and store indirect", 16'(mem[8'hD1]), 16'(w));
      chk("R4 load source untouched", 16'(mem[8'hC1]), 16'(w));
      if (d == 1) chk("R3 cycle count with two loads", 16'(lastCycles), 16'd42 + 16'(startCycles));
    end

    // R9: compare-and-jump grid
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] x, y;
        x = 8'(i * 17);
        y = 8'(j * 17);
        clearMem();
        emit({8'h20, x}); emit({8'h21, y});
        emit(16'hB110); emit(16'h2255); emit(16'hB014);
        pcB = 16'h10;
        emit(16'h22AA); emit(16'h0000); emit(16'h32F0);
        emit(16'hF120); emit(16'h2355); emit(16'hB024);
        pcB = 16'h20;
        emit(16'h23AA); emit(16'h0000); emit(16'h33F1); emit(16'hC000);
        runProg();
        chk("R9 jump equal", 16'(mem[8'hF0]), (y == x) ? 16'hAA : 16'h55);
        chk("R9 jump less or equal", 16'(mem[8'hF1]), (y <= x) ? 16'hAA : 16'h55);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule